// File: doc/BRIEF.md
# Multi-Level Power State Controller

This block sequences a microcontroller subsystem through five power states. The states are numbered 0 to 4 in rising order of power. In states 2, 3 and 4 the core can also run in one of three sub-modes: active, standby or sleep. Software asks for a new state and sub-mode with a one-cycle request strobe. Peripheral interrupts act as wake sources.

Every accepted change goes through a request/acknowledge handshake with the external supply and clock logic. The reported state changes only after that logic acknowledges. Until then the block is busy and refuses further requests. A request the block refuses sets a sticky error flag.

From the committed state, the block decodes the following outputs:
- a CPU clock enable;
- enables for the high-performance, low-power and analog peripheral domains;
- a main-RAM supply level;
- a voltage-level code;
- a CPU clock-select code.

A 32-byte backup register array stays readable and writable in every state.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the block reports state 4 with sub-mode active (mode code 0). In this state it enables the CPU clock and all three peripheral domains, drives RAM level 2, voltage code 2 and clock code 4, and reports busy and error as 0.
- R2: An accepted request or wake raises `sup_req` and `busy` in the next cycle. `cur_state` and `cur_mode` keep their values until `sup_ack` is sampled high. They take the target values in the cycle after that, and `busy` and `sup_req` then fall.
- R3: A request that arrives while `busy` is high is refused, sets `err`, and does not change the target of the transition in progress.
- R4: A request for state 1 is accepted only from state 2. From any other state it is refused, sets `err` and leaves the state unchanged.
- R5: A request for state 0 is accepted only from state 1. From any other state it is refused, sets `err` and leaves the state unchanged.
- R6: The block refuses the following requests and sets `err` for each:
  - any software request made in state 0, or in state 1 for a target other than 0;
  - a target above 4;
  - mode code 3;
  - a nonzero mode code with a target below 2.
- R7: In states 1 and 0, and in standby or sleep of states 2 to 4, a high `wake_irq` starts a handshake transition to active mode. The target is state 2 when starting from state 1 or 0, and the same state otherwise. A transition that returns to state 2 keeps the low-voltage choice last used in state 2. While the CPU runs in active mode, `wake_irq` has no effect.
- R8: Domain enables follow the state:
  - `hp_en` is 1 only in state 4;
  - `lp_en` is 1 in every state;
  - `ana_en` is 1 in every state except state 0.
- R9: `ram_pwr` follows the state and mode:
  - 0 (off) in state 0;
  - 1 (retention) in state 1, and in sleep mode (mode code 2) of states 2 to 4;
  - 2 (normal) otherwise.
- R10: `clk_sel` (0 none, 1 20 MHz, 2 32 MHz, 3 90 MHz, 4 180 MHz) and `vlevel` (0 low 0.7 V, 1 1.0 V, 2 1.1 V) follow the state:

  | State | `clk_sel` | `vlevel` |
  |---|---|---|
  | 4 | 4 | 2 |
  | 3 | 3 | 1 |
  | 2, low-voltage choice set | 1 | 0 |
  | 2, low-voltage choice clear | 2 | 1 |
  | 1 and 0 | 0 | 1 |
- R11: `cpu_clk_en` is 1 only in states 2 to 4 with mode code 0 (active). Mode codes 1 (standby) and 2 (sleep) turn it off.
- R12: `err` stays set until a cycle with `err_clr` high clears it. If a refused request arrives in the same cycle as `err_clr`, `err` stays set.
- R13: A byte written through `bkp_we`/`bkp_addr`/`bkp_wdata` is readable combinationally on `bkp_rdata` at the same address in every state, including state 0. It keeps its value through every state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Software request strobe |
| req_state | input | 3 | Requested state |
| req_mode | input | 2 | Requested sub-mode (0 active, 1 standby, 2 sleep) |
| req_lowv | input | 1 | Low-voltage 20 MHz choice for state 2 |
| wake_irq | input | 1 | Peripheral interrupt wake source |
| sup_ack | input | 1 | Supply/clock acknowledge |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| bkp_we | input | 1 | Backup array write enable |
| bkp_addr | input | 5 | Backup array byte address |
| bkp_wdata | input | 8 | Backup array write data |
| busy | output | 1 | Transition in progress |
| sup_req | output | 1 | Request to supply/clock logic |
| err | output | 1 | Sticky refused-request flag |
| cur_state | output | 3 | Committed power state |
| cur_mode | output | 2 | Committed sub-mode |
| cpu_clk_en | output | 1 | CPU clock enable |
| hp_en | output | 1 | High-performance peripheral domain enable |
| lp_en | output | 1 | Low-power peripheral domain enable |
| ana_en | output | 1 | Analog domain enable |
| ram_pwr | output | 2 | Main RAM level (0 off, 1 retention, 2 normal) |
| vlevel | output | 2 | Voltage-level code |
| clk_sel | output | 3 | CPU clock-select code |
| bkp_rdata | output | 8 | Backup array read data |

## Verification
The bench probes the two chained entries with requests for state 1 and state 0 from every wrong neighbour. A design that only checked the target's rank would let the chip fall straight from state 3 into retention, or from state 2 into power-off. It holds back the acknowledge for several cycles and sends a second request meanwhile. A controller that updated the state early, or let the late request retarget the transition, would report the wrong state. It wakes from state 0 and from standby and sleep, and checks that the state-2 clock choice survives the trip down and back. A block that lost it would come back on the wrong clock. Last, it reads the backup bytes after the state-0 visit, where a design tying them to main RAM power would return stale data.

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl #(
  parameter int BKP_BYTES = 32,
  parameter int BKP_DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [2:0]                   req_state,
  input  logic [1:0]                   req_mode,
  input  logic                         req_lowv,
  input  logic                         wake_irq,
  input  logic                         sup_ack,
  input  logic                         err_clr,
  input  logic                         bkp_we,
  input  logic [$clog2(BKP_BYTES)-1:0] bkp_addr,
  input  logic [BKP_DW-1:0]            bkp_wdata,
  output logic                         busy,
  output logic                         sup_req,
  output logic                         err,
  output logic [2:0]                   cur_state,
  output logic [1:0]                   cur_mode,
  output logic                         cpu_clk_en,
  output logic                         hp_en,
  output logic                         lp_en,
  output logic                         ana_en,
  output logic [1:0]                   ram_pwr,
  output logic [1:0]                   vlevel,
  output logic [2:0]                   clk_sel,
  output logic [BKP_DW-1:0]            bkp_rdata
);
  localparam logic [2:0] TOP_ST = 3'd4;
  localparam logic [1:0] MD_ACT = 2'd0;
  localparam logic [1:0] MD_SLP = 2'd2;

  logic [2:0] st_q, pst_q;
  logic [1:0] md_q, pmd_q;
  logic       lv_q, plv_q, busy_q, err_q;
  logic       req_bad;

  wire cpu_off = (st_q < 3'd2) || (md_q != MD_ACT);
  wire wake_go = wake_irq && !busy_q && cpu_off;
  wire req_go  = req_valid && !req_bad;

  always_comb begin
    req_bad = busy_q || wake_go
           || (req_state > TOP_ST) || (req_mode == 2'd3)
           || ((req_state < 3'd2) && (req_mode != MD_ACT))
           || (st_q == 3'd0)
           || ((st_q == 3'd1) && (req_state != 3'd0))
           || ((req_state == 3'd1) && (st_q != 3'd2))
           || ((req_state == 3'd0) && (st_q != 3'd1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= TOP_ST;
      md_q   <= MD_ACT;
      lv_q   <= 1'b0;
      pst_q  <= TOP_ST;
      pmd_q  <= MD_ACT;
      plv_q  <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wake_go) begin
        pst_q  <= (st_q < 3'd2) ? 3'd2 : st_q;
        pmd_q  <= MD_ACT;
        plv_q  <= lv_q;
        busy_q <= 1'b1;
      end else if (req_go) begin
        pst_q  <= req_state;
        pmd_q  <= req_mode;
        plv_q  <= (req_state == 3'd2) ? req_lowv : lv_q;
        busy_q <= 1'b1;
      end else if (busy_q && sup_ack) begin
        st_q   <= pst_q;
        md_q   <= pmd_q;
        lv_q   <= plv_q;
        busy_q <= 1'b0;
      end
      if (req_valid && req_bad) err_q <= 1'b1;
      else if (err_clr)         err_q <= 1'b0;
    end
  end

  logic [BKP_DW-1:0] bkp_mem [BKP_BYTES];
  always_ff @(posedge clk) begin
    if (bkp_we) bkp_mem[bkp_addr] <= bkp_wdata;
  end
  assign bkp_rdata = bkp_mem[bkp_addr];

  assign busy       = busy_q;
  assign sup_req    = busy_q;
  assign err        = err_q;
  assign cur_state  = st_q;
  assign cur_mode   = md_q;
  assign cpu_clk_en = !cpu_off;
  assign hp_en      = (st_q == TOP_ST);
  assign lp_en      = 1'b1;
  assign ana_en     = (st_q != 3'd0);
  assign ram_pwr    = (st_q == 3'd0) ? 2'd0
                    : ((st_q == 3'd1) || (md_q == MD_SLP)) ? 2'd1 : 2'd2;

  always_comb begin
    case (st_q)
      3'd4:    begin vlevel = 2'd2; clk_sel = 3'd4; end
      3'd3:    begin vlevel = 2'd1; clk_sel = 3'd3; end
      3'd2:    begin vlevel = lv_q ? 2'd0 : 2'd1; clk_sel = lv_q ? 3'd1 : 3'd2; end
      default: begin vlevel = 2'd1; clk_sel = 3'd0; end
    endcase
  end
endmodule

module pwr_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       sup_ack,
  input logic       err_clr,
  input logic       busy,
  input logic       sup_req,
  input logic       err,
  input logic [2:0] cur_state,
  input logic [1:0] cur_mode,
  input logic       ana_en,
  input logic [1:0] ram_pwr
);
  // R2
  hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_req && !sup_ack) |=> ($stable(cur_state) && $stable(cur_mode)));
  // R2
  hs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sup_ack) |=> !busy);
  // R3
  busy_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> err);
  // R4
  ps1_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_state == 3'd1) && ($past(cur_state) != 3'd1)) |-> ($past(cur_state) == 3'd2));
  // R5
  ps0_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_state == 3'd0) && ($past(cur_state) != 3'd0)) |-> ($past(cur_state) == 3'd1));
  // R9
  ram_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_pwr == 2'd0) |-> !ana_en);
  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);
  // R12
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(req_valid));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (.*);

// File: tb/tb_pwr_state_ctrl.sv
module tb_pwr_state_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_lowv = 0, wake_irq = 0, sup_ack = 0, err_clr = 0, bkp_we = 0;
  logic [2:0] req_state = 0;
  logic [1:0] req_mode = 0;
  logic [4:0] bkp_addr = 0;
  logic [7:0] bkp_wdata = 0;
  logic busy, sup_req, err, cpu_clk_en, hp_en, lp_en, ana_en;
  logic [2:0] cur_state, clk_sel;
  logic [1:0] cur_mode, ram_pwr, vlevel;
  logic [7:0] bkp_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  pwr_state_ctrl dut (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0] st; logic [1:0] md; logic lv; logic acc;
    logic [2:0] est; logic [1:0] emd; logic hp; logic ana;
    logic [1:0] ram; logic [1:0] vl; logic [2:0] cs; logic cpu;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{3'd3, 2'd0, 1'b0, 1'b1, 3'd3, 2'd0, 1'b0, 1'b1, 2'd2, 2'd1, 3'd3, 1'b1}, // R10
    '{3'd1, 2'd0, 1'b0, 1'b0, 3'd3, 2'd0, 1'b0, 1'b1, 2'd2, 2'd1, 3'd3, 1'b1}, // R4
    '{3'd2, 2'd0, 1'b1, 1'b1, 3'd2, 2'd0, 1'b0, 1'b1, 2'd2, 2'd0, 3'd1, 1'b1}, // R10
    '{3'd2, 2'd2, 1'b1, 1'b1, 3'd2, 2'd2, 1'b0, 1'b1, 2'd1, 2'd0, 3'd1, 1'b0}, // R9 R11
    '{3'd0, 2'd0, 1'b0, 1'b0, 3'd2, 2'd2, 1'b0, 1'b1, 2'd1, 2'd0, 3'd1, 1'b0}, // R5
    '{3'd2, 2'd0, 1'b0, 1'b1, 3'd2, 2'd0, 1'b0, 1'b1, 2'd2, 2'd1, 3'd2, 1'b1}, // R10
    '{3'd1, 2'd0, 1'b0, 1'b1, 3'd1, 2'd0, 1'b0, 1'b1, 2'd1, 2'd1, 3'd0, 1'b0}, // R4 R8
    '{3'd4, 2'd0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 2'd1, 2'd1, 3'd0, 1'b0}, // R6
    '{3'd0, 2'd0, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd1, 3'd0, 1'b0}, // R5 R8
    '{3'd1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd1, 3'd0, 1'b0}  // R6
  };

  task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  function automatic logic [20:0] observe();
    return {sup_req, cur_state, cur_mode, hp_en, ana_en, ram_pwr, vlevel, clk_sel, cpu_clk_en, lp_en, busy, 3'b0};
  endfunction

  function automatic logic [20:0] expect_of(input vec_t v);
    return {1'b0, v.est, v.emd, v.hp, v.ana, v.ram, v.vl, v.cs, v.cpu, 1'b1, 1'b0, 3'b0};
  endfunction

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic ack_after(input int dly);
    repeat (dly) @(negedge clk);
    sup_ack = 1;
    @(negedge clk); sup_ack = 0;
  endtask

  task automatic do_req(input logic [2:0] s, input logic [1:0] m, input logic lv, output bit acc);
    @(negedge clk);
    req_valid = 1; req_state = s; req_mode = m; req_lowv = lv;
    @(negedge clk);
    req_valid = 0;
    acc = sup_req;
    if (acc) ack_after(0);
  endtask

  task automatic do_wake(input string rq, input logic [2:0] est, input logic [1:0] emd);
    @(negedge clk); wake_irq = 1;
    @(negedge clk); wake_irq = 0;
    check({rq, " wake starts handshake"}, {30'd0, sup_req, busy}, 32'd3);
    ack_after(1);
    check({rq, " wake target"}, {27'd0, cur_state, cur_mode}, {27'd0, est, emd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 reset outputs", {11'd0, observe()}, {11'd0, 1'b0, 3'd4, 2'd0, 1'b1, 1'b1, 2'd2, 2'd2, 3'd4, 1'b1, 1'b1, 1'b0, 3'b0});
    check("R1 reset err", {31'd0, err}, 32'd0);

    // R13 fill backup array in state 4
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); bkp_we = 1; bkp_addr = 5'(i); bkp_wdata = 8'(i * 7 + 3);
    end
    @(negedge clk); bkp_we = 0;

    for (int i = 0; i < NV; i++) begin
      do_req(VEC[i].st, VEC[i].md, VEC[i].lv, acc);
      check($sformatf("R2/R4/R5/R6 vector %0d accept", i), {31'd0, acc}, {31'd0, VEC[i].acc});
      check($sformatf("R8/R9/R10/R11 vector %0d outputs", i), {11'd0, observe()}, {11'd0, expect_of(VEC[i])});
      check($sformatf("R12 vector %0d err", i), {31'd0, err}, {31'd0, !VEC[i].acc});
      pulse_clr();
      check($sformatf("R12 vector %0d err cleared", i), {31'd0, err}, 32'd0);
    end

    // R13 contents survive state 0
    begin
      int bad = 0;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk); bkp_addr = 5'(i);
        #1 if (bkp_rdata !== 8'(i * 7 + 3)) bad++;
      end
      check("R13 backup read in state 0", bad, 0);
    end
    @(negedge clk); bkp_we = 1; bkp_addr = 5'd9; bkp_wdata = 8'hA5;
    @(negedge clk); bkp_we = 0;
    #1 check("R13 backup write in state 0", {24'd0, bkp_rdata}, 32'hA5);

    // R7 wake from state 0, state-2 low-voltage choice (clear) retained
    do_wake("R7", 3'd2, 2'd0);
    check("R7 R10 clock after wake", {29'd0, clk_sel}, 32'd2);

    // R7 wake ignored in active mode
    @(negedge clk); wake_irq = 1;
    @(negedge clk); wake_irq = 0;
    check("R7 wake ignored when active", {30'd0, sup_req, busy}, 32'd0);

    // R11 standby in state 4, then wake
    do_req(3'd4, 2'd1, 1'b0, acc);
    check("R11 standby state 4", {25'd0, cur_state, hp_en, ram_pwr, cpu_clk_en}, {25'd0, 3'd4, 1'b1, 2'd2, 1'b0});
    do_wake("R7 standby", 3'd4, 2'd0);
    check("R11 cpu on after wake", {31'd0, cpu_clk_en}, 32'd1);

    // R2 R3 held acknowledge and request while busy
    @(negedge clk);
    req_valid = 1; req_state = 3'd3; req_mode = 2'd0;
    @(negedge clk);
    req_valid = 0;
    check("R2 busy after accept", {30'd0, sup_req, busy}, 32'd3);
    req_valid = 1; req_state = 3'd2; req_mode = 2'd0; req_lowv = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    check("R2 state held before ack", {29'd0, cur_state}, 32'd4);
    check("R3 err on busy request", {31'd0, err}, 32'd1);
    ack_after(0);
    check("R3 original target kept", {27'd0, cur_state, cur_mode}, {27'd0, 3'd3, 2'd0});
    check("R2 busy cleared", {30'd0, sup_req, busy}, 32'd0);

    // R12 set wins over clear
    @(negedge clk);
    req_valid = 1; req_state = 3'd5; err_clr = 1;
    @(negedge clk);
    req_valid = 0; err_clr = 0;
    check("R12 set beats clear", {31'd0, err}, 32'd1);
    check("R6 target above 4 refused", {29'd0, cur_state}, 32'd3);
    pulse_clr();

    // R6 mode 3 and nonzero mode below state 2
    do_req(3'd2, 2'd3, 1'b0, acc);
    check("R6 mode 3 refused", {30'd0, acc, err}, 32'd1);
    pulse_clr();
    do_req(3'd2, 2'd0, 1'b1, acc);
    do_req(3'd1, 2'd2, 1'b0, acc);
    check("R6 sleep mode to state 1 refused", {27'd0, acc, err, cur_state}, {27'd0, 1'b0, 1'b1, 3'd2});
    pulse_clr();

    // R7 wake from sleep in state 2, low-voltage choice kept
    do_req(3'd2, 2'd2, 1'b1, acc);
    do_wake("R7 sleep", 3'd2, 2'd0);
    check("R7 R10 low voltage kept", {27'd0, vlevel, clk_sel}, {27'd0, 2'd0, 3'd1});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule